// File: doc/BRIEF.md
# Fixed-Width Instruction Decoder

This block turns one 32-bit instruction into the control bundle that an execution stage consumes. The fetch side hands it an eight-byte window of memory in big-endian byte order together with a two-bit byte offset. The instruction is the four bytes that start at that offset, so instructions need not be aligned. The first byte of the instruction is the opcode. The other three bytes are register selectors or a 16-bit big-endian immediate, depending on which of six operand layouts the opcode implies.

The decoder translates the sparse 8-bit register selectors into dense register-file indices. The instruction pointer is selectable like any other register and gets physical index 10. The control bundle carries the ALU operation, compare, write-back enable, immediate select, branch kind, memory access kind, stack action, byte I/O action and system action. An opcode outside the map, or a bad selector in a field the layout uses, raises the illegal output and silences every control field. Results are registered and appear one cycle after the input is marked valid.

Top module: `insn_decoder`

## Requirements
- R1: While rst_n is low, and on the first cycle after a clock edge sampled with rst_n low, every output is zero.
- R2: The instruction is window bytes off..off+3, where window byte 0 is bits 63:56 of fetch_win_i. Byte off is the opcode, byte off+1 is field A, byte off+2 is field B and byte off+3 is field C. Bytes off+2..off+3 form the immediate, high byte first.
- R3: Selectors 0x00-0x06 map to indices 0-6. Selector 0x0A maps to 7, 0x08 to 8, 0x09 to 9 and 0x07 (instruction pointer) to 10.
- R4: Opcodes 0x10-0x1F are arithmetic, with alu_op = ((opcode-0x10)>>1)+1 (add 1, sub 2, mul 3, div 4, mod 5, and 6, or 7, xor 8) and wb_en=1. An even opcode uses layout A+B+C (fmt 3). An odd opcode uses layout A+imm (fmt 4).
- R5: When fmt is 4 (A+imm) or 5 (imm only), use_imm_o=1 and imm_o holds the immediate. In every other case both are zero.
- R6: Bytes the layout does not use are ignored. Their index outputs are 0 and they never cause illegal_o. Layout codes: 0 opcode only, 1 A, 2 A+B, 3 A+B+C, 4 A+imm, 5 imm.
- R7: Opcodes 0x20-0x26 use fmt 5 with br_type = opcode[3:0]+1 (jmp 1, eq 2, ne 3, lt 4, le 5, gt 6, ge 7). 0x28 uses fmt 1 with br_type 8, call_reg 1 and stk_op push (1). 0x29 uses fmt 0 with br_type 9 and stk_op pop (2).
- R8: 0x53 (fmt 2) and 0x54 (fmt 4) give cmp_o=1, alu_op 2 (subtract) and wb_en 0.
- R9: Opcodes 0x30-0x37 give mem_type = opcode[2:1]+1 (load16 1, load8 2, store16 3, store8 4). Even opcodes use fmt 4 and odd opcodes use fmt 2. wb_en is set for the two loads only.
- R10: 0x42 is fmt 1 push. 0x43 is fmt 5 push. 0x44 is fmt 1 pop with wb_en. 0x40 is fmt 1 with io_op 1 (input) and wb_en. 0x41 is fmt 1 with io_op 2 (output). 0x51 (fmt 2) and 0x52 (fmt 4) give alu_op 9 (pass) with wb_en.
- R11: 0x60 gives sys_op 1 (halt), 0x61 gives sys_op 2 (system call) and 0x90 leaves every control field zero. All three use fmt 0.
- R12: An opcode outside the map sets illegal_o=1. All control, format, index and immediate outputs are then zero, while opcode_o still shows the opcode.
- R13: A selector above 0x0A in a field the layout uses sets illegal_o=1, with the same zeroed outputs as R12.
- R14: Outputs reflect the input sampled at the previous clock edge. A cycle sampled with in_valid_i low gives out_valid_o=0 and all other outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Window and offset are valid this cycle |
| fetch_win_i | input | 64 | Eight bytes of memory, byte 0 in the top bits |
| byte_off_i | input | 2 | Start byte of the instruction in the window |
| out_valid_o | output | 1 | Decoded bundle is valid |
| opcode_o | output | 8 | Opcode byte |
| fmt_o | output | 3 | Operand layout code |
| ra_idx_o | output | 4 | Physical index of field A |
| rb_idx_o | output | 4 | Physical index of field B |
| rc_idx_o | output | 4 | Physical index of field C |
| imm_o | output | 16 | Immediate operand |
| use_imm_o | output | 1 | Immediate replaces a register operand |
| alu_op_o | output | 4 | ALU operation code |
| cmp_o | output | 1 | Result goes to flags only |
| wb_en_o | output | 1 | Field A register is written |
| br_type_o | output | 4 | Branch kind |
| call_reg_o | output | 1 | Register A holds the relative call offset |
| mem_type_o | output | 3 | Memory access kind |
| stk_op_o | output | 2 | Stack action |
| io_op_o | output | 2 | Byte I/O action |
| sys_op_o | output | 2 | Halt or system call |
| illegal_o | output | 1 | Illegal instruction |

## Verification
The properties assume that in_valid_i, fetch_win_i and byte_off_i carry known values at every sampling edge once reset is released. They also assume that reset is held for at least one edge before the first valid instruction. The bench drives every input from known constants, and it changes them only on falling edges, half a period away from the capturing edge. Selectors above 0x0A, undefined opcodes and junk in unused bytes are applied on purpose, because the decoder must classify them rather than assume them away.

// File: rtl/insn_dec_pkg.sv
// Shared types for the instruction decoder: operand layouts, control
// codes, opcode constants and register selector codes.
// Assumes the 8-bit opcode and selector encodings listed in the brief.
package insn_dec_pkg;

    typedef enum logic [2:0] {
        FMT_NONE = 3'd0,
        FMT_A    = 3'd1,
        FMT_AB   = 3'd2,
        FMT_ABC  = 3'd3,
        FMT_AI   = 3'd4,
        FMT_I    = 3'd5
    } fmt_e;

    typedef enum logic [3:0] {
        ALU_NONE = 4'd0,
        ALU_ADD  = 4'd1,
        ALU_SUB  = 4'd2,
        ALU_MUL  = 4'd3,
        ALU_DIV  = 4'd4,
        ALU_MOD  = 4'd5,
        ALU_AND  = 4'd6,
        ALU_OR   = 4'd7,
        ALU_XOR  = 4'd8,
        ALU_PASS = 4'd9
    } alu_e;

    typedef enum logic [3:0] {
        BR_NONE = 4'd0,
        BR_JMP  = 4'd1,
        BR_EQ   = 4'd2,
        BR_NE   = 4'd3,
        BR_LT   = 4'd4,
        BR_LE   = 4'd5,
        BR_GT   = 4'd6,
        BR_GE   = 4'd7,
        BR_CALL = 4'd8,
        BR_RET  = 4'd9
    } br_e;

    typedef enum logic [2:0] {
        MEM_NONE = 3'd0,
        MEM_LD16 = 3'd1,
        MEM_LD8  = 3'd2,
        MEM_ST16 = 3'd3,
        MEM_ST8  = 3'd4
    } mem_e;

    typedef enum logic [1:0] {
        STK_NONE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_e;

    typedef enum logic [1:0] {
        IO_NONE = 2'd0,
        IO_IN   = 2'd1,
        IO_OUT  = 2'd2
    } io_e;

    typedef enum logic [1:0] {
        SYS_NONE = 2'd0,
        SYS_HALT = 2'd1,
        SYS_CALL = 2'd2
    } sys_e;

    typedef struct packed {
        fmt_e fmt;
        alu_e alu;
        logic cmp;
        logic wb;
        br_e  br;
        logic call_reg;
        mem_e mem;
        stk_e stk;
        io_e  io;
        sys_e sys;
    } ctrl_t;

    // Opcode groups decoded by bit field
    localparam logic [3:0] OP_ARITH_HI = 4'h1;      // 0x10..0x1F
    localparam logic [4:0] OP_MEM_HI   = 5'b00110;  // 0x30..0x37

    // Individually decoded opcodes
    localparam logic [7:0] OP_JMP   = 8'h20;
    localparam logic [7:0] OP_JEQ   = 8'h21;
    localparam logic [7:0] OP_JNE   = 8'h22;
    localparam logic [7:0] OP_JLT   = 8'h23;
    localparam logic [7:0] OP_JLE   = 8'h24;
    localparam logic [7:0] OP_JGT   = 8'h25;
    localparam logic [7:0] OP_JGE   = 8'h26;
    localparam logic [7:0] OP_CALLR = 8'h28;
    localparam logic [7:0] OP_RET   = 8'h29;
    localparam logic [7:0] OP_IN    = 8'h40;
    localparam logic [7:0] OP_OUT   = 8'h41;
    localparam logic [7:0] OP_PUSHR = 8'h42;
    localparam logic [7:0] OP_PUSHI = 8'h43;
    localparam logic [7:0] OP_POP   = 8'h44;
    localparam logic [7:0] OP_MOVR  = 8'h51;
    localparam logic [7:0] OP_MOVI  = 8'h52;
    localparam logic [7:0] OP_CMPR  = 8'h53;
    localparam logic [7:0] OP_CMPI  = 8'h54;
    localparam logic [7:0] OP_HLT   = 8'h60;
    localparam logic [7:0] OP_SYSC  = 8'h61;
    localparam logic [7:0] OP_NOP   = 8'h90;

    // Register selector codes that do not map to themselves
    localparam logic [7:0] SEL_IP = 8'h07;
    localparam logic [7:0] SEL_BP = 8'h08;
    localparam logic [7:0] SEL_SP = 8'h09;
    localparam logic [7:0] SEL_G7 = 8'h0A;

    // Physical register-file indices
    localparam int PHY_G7 = 7;
    localparam int PHY_IP = 10;

endpackage

// File: rtl/insn_byte_align.sv
// Byte aligner: picks INSN_BYTES consecutive bytes out of a big-endian
// window, starting at byte off_i. Byte 0 is the top byte of win_i.
// Assumes WIN_BYTES >= 2*INSN_BYTES - 1 so every offset stays in range.
module insn_byte_align #(
    parameter int WIN_BYTES  = 8,
    parameter int INSN_BYTES = 4,
    localparam int OFF_W  = $clog2(INSN_BYTES),
    localparam int WIN_W  = 8 * WIN_BYTES,
    localparam int INSN_W = 8 * INSN_BYTES
) (
    input  logic [WIN_W-1:0]  win_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [INSN_W-1:0] word_o
);

    logic [INSN_W-1:0] cand [INSN_BYTES];

    // One candidate word per legal start offset
    for (genvar k = 0; k < INSN_BYTES; k++) begin : g_cand
        assign cand[k] = win_i[WIN_W-1-8*k -: INSN_W];
    end

    // Offset selects the candidate
    assign word_o = cand[off_i];

endmodule

// File: rtl/insn_reg_map.sv
// Register selector map: translates one 8-bit selector into a dense
// register-file index and flags selectors outside the defined set.
// Assumes IDX_W is wide enough for index 10.
module insn_reg_map
    import insn_dec_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [7:0]       sel_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             ok_o
);

    // Sparse selector to dense index
    always_comb begin
        ok_o  = 1'b1;
        idx_o = '0;
        case (sel_i)
            8'h00, 8'h01, 8'h02, 8'h03,
            8'h04, 8'h05, 8'h06,
            SEL_BP, SEL_SP: idx_o = IDX_W'(sel_i);
            SEL_G7:         idx_o = IDX_W'(PHY_G7);
            SEL_IP:         idx_o = IDX_W'(PHY_IP);
            default:        ok_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/insn_opc_decode.sv
// Opcode decoder: derives the operand layout and the control bundle from
// the opcode byte alone, and reports whether the opcode is defined.
// Assumes nothing about the other instruction bytes.
module insn_opc_decode
    import insn_dec_pkg::*;
(
    input  logic [7:0] opc_i,
    output ctrl_t      ctrl_o,
    output logic       known_o
);

    // Group decode by bit field, then single opcodes
    always_comb begin
        ctrl_o  = '0;
        known_o = 1'b1;
        if (opc_i[7:4] == OP_ARITH_HI) begin
            ctrl_o.fmt = opc_i[0] ? FMT_AI : FMT_ABC;
            ctrl_o.alu = alu_e'({1'b0, opc_i[3:1]} + 4'd1);
            ctrl_o.wb  = 1'b1;
        end else if (opc_i[7:3] == OP_MEM_HI) begin
            ctrl_o.fmt = opc_i[0] ? FMT_AB : FMT_AI;
            ctrl_o.mem = mem_e'({1'b0, opc_i[2:1]} + 3'd1);
            ctrl_o.wb  = ~opc_i[2];
        end else begin
            case (opc_i)
                OP_JMP, OP_JEQ, OP_JNE, OP_JLT,
                OP_JLE, OP_JGT, OP_JGE: begin
                    ctrl_o.fmt = FMT_I;
                    ctrl_o.br  = br_e'(opc_i[3:0] + 4'd1);
                end
                OP_CALLR: begin
                    ctrl_o.fmt      = FMT_A;
                    ctrl_o.br       = BR_CALL;
                    ctrl_o.call_reg = 1'b1;
                    ctrl_o.stk      = STK_PUSH;
                end
                OP_RET: begin
                    ctrl_o.br  = BR_RET;
                    ctrl_o.stk = STK_POP;
                end
                OP_IN: begin
                    ctrl_o.fmt = FMT_A;
                    ctrl_o.io  = IO_IN;
                    ctrl_o.wb  = 1'b1;
                end
                OP_OUT: begin
                    ctrl_o.fmt = FMT_A;
                    ctrl_o.io  = IO_OUT;
                end
                OP_PUSHR: begin
                    ctrl_o.fmt = FMT_A;
                    ctrl_o.stk = STK_PUSH;
                end
                OP_PUSHI: begin
                    ctrl_o.fmt = FMT_I;
                    ctrl_o.stk = STK_PUSH;
                end
                OP_POP: begin
                    ctrl_o.fmt = FMT_A;
                    ctrl_o.stk = STK_POP;
                    ctrl_o.wb  = 1'b1;
                end
                OP_MOVR: begin
                    ctrl_o.fmt = FMT_AB;
                    ctrl_o.alu = ALU_PASS;
                    ctrl_o.wb  = 1'b1;
                end
                OP_MOVI: begin
                    ctrl_o.fmt = FMT_AI;
                    ctrl_o.alu = ALU_PASS;
                    ctrl_o.wb  = 1'b1;
                end
                OP_CMPR: begin
                    ctrl_o.fmt = FMT_AB;
                    ctrl_o.alu = ALU_SUB;
                    ctrl_o.cmp = 1'b1;
                end
                OP_CMPI: begin
                    ctrl_o.fmt = FMT_AI;
                    ctrl_o.alu = ALU_SUB;
                    ctrl_o.cmp = 1'b1;
                end
                OP_HLT:  ctrl_o.sys = SYS_HALT;
                OP_SYSC: ctrl_o.sys = SYS_CALL;
                OP_NOP:  ctrl_o.fmt = FMT_NONE;
                default: known_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/insn_decoder.sv
// Instruction decoder top: aligns the instruction out of the fetch
// window, decodes the opcode, maps the used register fields, checks
// legality and registers the resulting bundle for one cycle of latency.
// Assumes a synchronous active-low reset and known inputs when valid.
module insn_decoder
    import insn_dec_pkg::*;
#(
    parameter int WIN_BYTES = 8,
    parameter int IDX_W     = 4,
    localparam int INSN_BYTES = 4,
    localparam int OFF_W      = $clog2(INSN_BYTES),
    localparam int IMM_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid_i,
    input  logic [8*WIN_BYTES-1:0] fetch_win_i,
    input  logic [OFF_W-1:0]       byte_off_i,
    output logic                   out_valid_o,
    output logic [7:0]             opcode_o,
    output logic [2:0]             fmt_o,
    output logic [IDX_W-1:0]       ra_idx_o,
    output logic [IDX_W-1:0]       rb_idx_o,
    output logic [IDX_W-1:0]       rc_idx_o,
    output logic [IMM_W-1:0]       imm_o,
    output logic                   use_imm_o,
    output logic [3:0]             alu_op_o,
    output logic                   cmp_o,
    output logic                   wb_en_o,
    output logic [3:0]             br_type_o,
    output logic                   call_reg_o,
    output logic [2:0]             mem_type_o,
    output logic [1:0]             stk_op_o,
    output logic [1:0]             io_op_o,
    output logic [1:0]             sys_op_o,
    output logic                   illegal_o
);

    localparam int NFIELD = INSN_BYTES - 1;
    localparam int INSN_W = 8 * INSN_BYTES;

    logic [INSN_W-1:0] word;
    logic [7:0]        opc;
    logic [7:0]        sel    [NFIELD];
    logic [IDX_W-1:0]  idx    [NFIELD];
    logic [NFIELD-1:0] sel_ok;
    logic [NFIELD-1:0] used;
    ctrl_t             ctrl;
    logic              known;
    logic              illegal;
    logic              has_imm;

    ctrl_t             n_ctrl;
    logic [IDX_W-1:0]  n_idx  [NFIELD];
    logic [IMM_W-1:0]  n_imm;

    ctrl_t             ctrl_q;
    logic [IDX_W-1:0]  idx_q  [NFIELD];
    logic [IMM_W-1:0]  imm_q;
    logic              uimm_q;
    logic              ill_q;
    logic [7:0]        opc_q;
    logic              vld_q;

    insn_byte_align #(
        .WIN_BYTES  (WIN_BYTES),
        .INSN_BYTES (INSN_BYTES)
    ) align_i (
        .win_i  (fetch_win_i),
        .off_i  (byte_off_i),
        .word_o (word)
    );

    assign opc = word[INSN_W-1 -: 8];

    insn_opc_decode opc_i (
        .opc_i   (opc),
        .ctrl_o  (ctrl),
        .known_o (known)
    );

    // One selector map per register field (A, B, C)
    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        assign sel[f] = word[8*(NFIELD-1-f) +: 8];
        insn_reg_map #(.IDX_W(IDX_W)) map_i (
            .sel_i (sel[f]),
            .idx_o (idx[f]),
            .ok_o  (sel_ok[f])
        );
    end

    // Which register fields the layout consumes
    always_comb begin
        used = '0;
        case (ctrl.fmt)
            FMT_A, FMT_AI: used = 3'b001;
            FMT_AB:        used = 3'b011;
            FMT_ABC:       used = 3'b111;
            default:       used = 3'b000;
        endcase
    end

    // Legality and gating of the next bundle
    always_comb begin
        illegal = !known || ((used & ~sel_ok) != '0);
        has_imm = !illegal && (ctrl.fmt == FMT_AI || ctrl.fmt == FMT_I);
        n_ctrl  = illegal ? '0 : ctrl;
        n_imm   = has_imm ? word[IMM_W-1:0] : '0;
        for (int f = 0; f < NFIELD; f++) begin
            n_idx[f] = (used[f] && !illegal) ? idx[f] : '0;
        end
    end

    // Output register: load on valid, clear on idle or reset
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid_i) begin
            ctrl_q <= '0;
            imm_q  <= '0;
            uimm_q <= 1'b0;
            ill_q  <= 1'b0;
            opc_q  <= '0;
            vld_q  <= 1'b0;
            for (int f = 0; f < NFIELD; f++) idx_q[f] <= '0;
        end else begin
            ctrl_q <= n_ctrl;
            imm_q  <= n_imm;
            uimm_q <= has_imm;
            ill_q  <= illegal;
            opc_q  <= opc;
            vld_q  <= 1'b1;
            for (int f = 0; f < NFIELD; f++) idx_q[f] <= n_idx[f];
        end
    end

    assign out_valid_o = vld_q;
    assign opcode_o    = opc_q;
    assign fmt_o       = ctrl_q.fmt;
    assign ra_idx_o    = idx_q[0];
    assign rb_idx_o    = idx_q[1];
    assign rc_idx_o    = idx_q[2];
    assign imm_o       = imm_q;
    assign use_imm_o   = uimm_q;
    assign alu_op_o    = ctrl_q.alu;
    assign cmp_o       = ctrl_q.cmp;
    assign wb_en_o     = ctrl_q.wb;
    assign br_type_o   = ctrl_q.br;
    assign call_reg_o  = ctrl_q.call_reg;
    assign mem_type_o  = ctrl_q.mem;
    assign stk_op_o    = ctrl_q.stk;
    assign io_op_o     = ctrl_q.io;
    assign sys_op_o    = ctrl_q.sys;
    assign illegal_o   = ill_q;

endmodule

// File: rtl/insn_decoder_chk.sv
// Property checker for insn_decoder, attached by bind. Observes ports
// only; assumes known inputs after reset release.
module insn_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid_i,
    input logic        out_valid_o,
    input logic [7:0]  opcode_o,
    input logic [2:0]  fmt_o,
    input logic [3:0]  ra_idx_o,
    input logic [3:0]  rb_idx_o,
    input logic [3:0]  rc_idx_o,
    input logic [15:0] imm_o,
    input logic        use_imm_o,
    input logic [3:0]  alu_op_o,
    input logic        cmp_o,
    input logic        wb_en_o,
    input logic [3:0]  br_type_o,
    input logic        call_reg_o,
    input logic [2:0]  mem_type_o,
    input logic [1:0]  stk_op_o,
    input logic        illegal_o
);

    a_r14_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    a_r14_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);

    a_r14_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (opcode_o == 8'h00 && !illegal_o && fmt_o == 3'd0));

    a_r12_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (fmt_o == 3'd0 && alu_op_o == 4'd0 && br_type_o == 4'd0
                       && mem_type_o == 3'd0 && stk_op_o == 2'd0 && !wb_en_o
                       && imm_o == 16'h0000 && ra_idx_o == 4'd0));

    a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !illegal_o) |->
            (ra_idx_o <= 4'd10 && rb_idx_o <= 4'd10 && rc_idx_o <= 4'd10));

    a_r5_imm_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !use_imm_o |-> (imm_o == 16'h0000));

    a_r8_cmp_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_o |-> (!wb_en_o && alu_op_o == 4'd2));

    a_r7_call_reg_push: assert property (@(posedge clk) disable iff (!rst_n)
        call_reg_o |-> (br_type_o == 4'd8 && stk_op_o == 2'd1 && fmt_o == 3'd1));

    a_r6_unused_c: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_o != 3'd3) |-> (rc_idx_o == 4'd0));

endmodule

bind insn_decoder insn_decoder_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .out_valid_o (out_valid_o),
    .opcode_o    (opcode_o),
    .fmt_o       (fmt_o),
    .ra_idx_o    (ra_idx_o),
    .rb_idx_o    (rb_idx_o),
    .rc_idx_o    (rc_idx_o),
    .imm_o       (imm_o),
    .use_imm_o   (use_imm_o),
    .alu_op_o    (alu_op_o),
    .cmp_o       (cmp_o),
    .wb_en_o     (wb_en_o),
    .br_type_o   (br_type_o),
    .call_reg_o  (call_reg_o),
    .mem_type_o  (mem_type_o),
    .stk_op_o    (stk_op_o),
    .illegal_o   (illegal_o)
);

// File: tb/insn_decoder_tb_top.sv
`timescale 1ns/1ps
module insn_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] win = '0;
    logic [1:0]  off = '0;

    logic        out_valid_o;
    logic [7:0]  opcode_o;
    logic [2:0]  fmt_o;
    logic [3:0]  ra_idx_o, rb_idx_o, rc_idx_o;
    logic [15:0] imm_o;
    logic        use_imm_o;
    logic [3:0]  alu_op_o;
    logic        cmp_o, wb_en_o;
    logic [3:0]  br_type_o;
    logic        call_reg_o;
    logic [2:0]  mem_type_o;
    logic [1:0]  stk_op_o, io_op_o, sys_op_o;
    logic        illegal_o;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    insn_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid),
        .fetch_win_i(win), .byte_off_i(off),
        .out_valid_o(out_valid_o), .opcode_o(opcode_o), .fmt_o(fmt_o),
        .ra_idx_o(ra_idx_o), .rb_idx_o(rb_idx_o), .rc_idx_o(rc_idx_o),
        .imm_o(imm_o), .use_imm_o(use_imm_o), .alu_op_o(alu_op_o),
        .cmp_o(cmp_o), .wb_en_o(wb_en_o), .br_type_o(br_type_o),
        .call_reg_o(call_reg_o), .mem_type_o(mem_type_o),
        .stk_op_o(stk_op_o), .io_op_o(io_op_o), .sys_op_o(sys_op_o),
        .illegal_o(illegal_o)
    );

    // Bundle: fmt ra rb rc imm use_imm alu cmp wb br call_reg mem stk io sys ill
    logic [52:0] act;
    assign act = {fmt_o, ra_idx_o, rb_idx_o, rc_idx_o, imm_o, use_imm_o,
                  alu_op_o, cmp_o, wb_en_o, br_type_o, call_reg_o,
                  mem_type_o, stk_op_o, io_op_o, sys_op_o, illegal_o};

    // Entry: {req number, instruction word, expected bundle}
    localparam int NV = 39;
    localparam logic [88:0] VEC [NV] = '{
        // R4 R3 add three-register, rip and r7 selectors
        {4'd4, 32'h1001070A, 3'd3,4'd1,4'd10,4'd7,16'h0000,1'b0,4'd1,1'b0,1'b1,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        // R4 xor immediate
        {4'd4, 32'h1F0A1234, 3'd4,4'd7,4'd0,4'd0,16'h1234,1'b1,4'd8,1'b0,1'b1,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        // R3 rbp, rsp selectors
        {4'd3, 32'h14080900, 3'd3,4'd8,4'd9,4'd0,16'h0000,1'b0,4'd3,1'b0,1'b1,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        // R5 mod immediate
        {4'd5, 32'h1902FFFE, 3'd4,4'd2,4'd0,4'd0,16'hFFFE,1'b1,4'd5,1'b0,1'b1,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        // R8 cmp reg/reg, byte 3 junk
        {4'd8, 32'h53030977, 3'd2,4'd3,4'd9,4'd0,16'h0000,1'b0,4'd2,1'b1,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        // R8 cmp reg/imm
        {4'd8, 32'h54070005, 3'd4,4'd10,4'd0,4'd0,16'h0005,1'b1,4'd2,1'b1,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        // R7 jmp
        {4'd7, 32'h20FFFFE8, 3'd5,4'd0,4'd0,4'd0,16'hFFE8,1'b1,4'd0,1'b0,1'b0,4'd1,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        // R7 conditional branches
        {4'd7, 32'h21000010, 3'd5,4'd0,4'd0,4'd0,16'h0010,1'b1,4'd0,1'b0,1'b0,4'd2,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        {4'd7, 32'h22000004, 3'd5,4'd0,4'd0,4'd0,16'h0004,1'b1,4'd0,1'b0,1'b0,4'd3,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        {4'd7, 32'h2333FFFC, 3'd5,4'd0,4'd0,4'd0,16'hFFFC,1'b1,4'd0,1'b0,1'b0,4'd4,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        {4'd7, 32'h24000002, 3'd5,4'd0,4'd0,4'd0,16'h0002,1'b1,4'd0,1'b0,1'b0,4'd5,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        {4'd7, 32'h25000001, 3'd5,4'd0,4'd0,4'd0,16'h0001,1'b1,4'd0,1'b0,1'b0,4'd6,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        {4'd7, 32'h26AB8000, 3'd5,4'd0,4'd0,4'd0,16'h8000,1'b1,4'd0,1'b0,1'b0,4'd7,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        // R7 call through register, ret
        {4'd7, 32'h2806C3C3, 3'd1,4'd6,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd8,1'b1,3'd0,2'd1,2'd0,2'd0,1'b0},
        {4'd7, 32'h29FFFFFF, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd9,1'b0,3'd0,2'd2,2'd0,2'd0,1'b0},
        // R9 memory access forms
        {4'd9, 32'h30040040, 3'd4,4'd4,4'd0,4'd0,16'h0040,1'b1,4'd0,1'b0,1'b1,4'd0,1'b0,3'd1,2'd0,2'd0,2'd0,1'b0},
        {4'd9, 32'h330102EE, 3'd2,4'd1,4'd2,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b1,4'd0,1'b0,3'd2,2'd0,2'd0,2'd0,1'b0},
        {4'd9, 32'h35000100, 3'd2,4'd0,4'd1,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd3,2'd0,2'd0,2'd0,1'b0},
        {4'd9, 32'h36050041, 3'd4,4'd5,4'd0,4'd0,16'h0041,1'b1,4'd0,1'b0,1'b0,4'd0,1'b0,3'd4,2'd0,2'd0,2'd0,1'b0},
        // R10 stack, byte I/O, move
        {4'd10, 32'h420A9999, 3'd1,4'd7,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd1,2'd0,2'd0,1'b0},
        {4'd10, 32'h43FF0090, 3'd5,4'd0,4'd0,4'd0,16'h0090,1'b1,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd1,2'd0,2'd0,1'b0},
        {4'd10, 32'h44090000, 3'd1,4'd9,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b1,4'd0,1'b0,3'd0,2'd2,2'd0,2'd0,1'b0},
        {4'd10, 32'h40025555, 3'd1,4'd2,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b1,4'd0,1'b0,3'd0,2'd0,2'd1,2'd0,1'b0},
        {4'd10, 32'h41070000, 3'd1,4'd10,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd2,2'd0,1'b0},
        {4'd10, 32'h51030700, 3'd2,4'd3,4'd10,4'd0,16'h0000,1'b0,4'd9,1'b0,1'b1,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        {4'd10, 32'h5208ABCD, 3'd4,4'd8,4'd0,4'd0,16'hABCD,1'b1,4'd9,1'b0,1'b1,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        // R11 halt, system call, no-op
        {4'd11, 32'h60123456, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd1,1'b0},
        {4'd11, 32'h61FFFFFF, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd2,1'b0},
        {4'd11, 32'h90123456, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        // R12 undefined opcodes
        {4'd12, 32'h27010203, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b1},
        {4'd12, 32'h00000000, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b1},
        {4'd12, 32'hFF000000, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b1},
        {4'd12, 32'h38000000, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b1},
        {4'd12, 32'h45000000, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b1},
        // R13 bad selector in a used field
        {4'd13, 32'h10010B02, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b1},
        {4'd13, 32'h11FF0001, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b1},
        // R6 bad selector in an unused field is ignored
        {4'd6, 32'h42050BFF, 3'd1,4'd5,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd1,2'd0,2'd0,1'b0},
        {4'd6, 32'h2047FFFF, 3'd5,4'd0,4'd0,4'd0,16'hFFFF,1'b1,4'd0,1'b0,1'b0,4'd1,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0},
        // R13 bad field B of cmp reg/reg
        {4'd13, 32'h5307AA00, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b1}
    };

    task automatic chk(input string req, input logic [63:0] a, input logic [63:0] e);
        nchk++;
        if (a !== e) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    // Drive on a falling edge; result readable on the next falling edge
    task automatic apply(input logic v, input logic [63:0] w, input logic [1:0] o);
        @(negedge clk);
        in_valid = v;
        win      = w;
        off      = o;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 bundle", {11'd0, act}, 64'd0);
        chk("R1 valid/opcode", {55'd0, out_valid_o, opcode_o}, 64'd0);
        rst_n = 1'b1;

        // Table walk, offset 0
        for (int i = 0; i < NV; i++) begin
            apply(1'b1, {VEC[i][84:53], 32'hDEADBEEF}, 2'd0);
            chk($sformatf("R%0d vec%0d bundle", VEC[i][88:85], i),
                {11'd0, act}, {11'd0, VEC[i][52:0]});
            chk($sformatf("R14 vec%0d valid/opcode", i),
                {55'd0, out_valid_o, opcode_o}, {55'd0, 1'b1, VEC[i][84:77]});
        end

        // R2 offset 1: mov imm
        apply(1'b1, {8'hAA, 32'h52011234, 24'h000000}, 2'd1);
        chk("R2 off1", {11'd0, act},
            {11'd0, 3'd4,4'd1,4'd0,4'd0,16'h1234,1'b1,4'd9,1'b0,1'b1,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0});
        chk("R2 off1 opcode", {56'd0, opcode_o}, 64'h52);

        // R2 offset 2: ret, byte 0 holds a branch opcode
        apply(1'b1, {16'h2100, 32'h29000000, 16'h0000}, 2'd2);
        chk("R2 off2", {11'd0, act},
            {11'd0, 3'd0,4'd0,4'd0,4'd0,16'h0000,1'b0,4'd0,1'b0,1'b0,4'd9,1'b0,3'd0,2'd2,2'd0,2'd0,1'b0});

        // R2 offset 3: add imm
        apply(1'b1, {24'hFFFFFF, 32'h11020007, 8'hFF}, 2'd3);
        chk("R2 off3", {11'd0, act},
            {11'd0, 3'd4,4'd2,4'd0,4'd0,16'h0007,1'b1,4'd1,1'b0,1'b1,4'd0,1'b0,3'd0,2'd0,2'd0,2'd0,1'b0});

        // R14 idle cycle clears the outputs
        apply(1'b0, {32'h1001070A, 32'h0}, 2'd0);
        chk("R14 idle bundle", {11'd0, act}, 64'd0);
        chk("R14 idle valid/opcode", {55'd0, out_valid_o, opcode_o}, 64'd0);

        // R1 reset in mid-stream with valid input held
        apply(1'b1, {32'h1F0A1234, 32'h0}, 2'd0);
        chk("R14 pre-reset valid", {63'd0, out_valid_o}, 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run bundle", {11'd0, act}, 64'd0);
        chk("R1 mid-run valid/opcode", {55'd0, out_valid_o, opcode_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R14 post-reset valid", {55'd0, out_valid_o, opcode_o}, {55'd0, 1'b1, 8'h1F});
        in_valid = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule